// File: doc/BRIEF.md
# Raster Timing Generator with Shift-Register Counters

This block produces the horizontal sync, vertical sync and display-enable strobes for a raster display. It also produces plain binary pixel coordinates for the visible area. Its two position counters are not binary adders. Each one is a 16-bit shift register with linear feedback, which keeps the carry path short at high pixel rates. Because of that, every timing boundary is programmed as the shift-register state reached after N steps from the all-ones seed, not as the number N. The block compares each counter state for equality against those pre-encoded boundary words.

Software computes the encoded boundary words once per video mode and holds them steady on the inputs. The visible width and height are supplied in plain binary and limit display-enable. A two-bit display mode input selects among three states: normal output, blanked picture with live syncs, or a fully quiet power-down. A small state machine applies the mode one clock after it is requested. Its states are `DISP_ON`, `DISP_BLANK` and `DISP_OFF`. Reset places it in `DISP_OFF`. At every clock it moves to the state named by the mode input: code 0 goes to `DISP_ON`, code 1 to `DISP_BLANK`, and codes 2 and 3 to `DISP_OFF`. It can move between any two states in one step.

Top module: `lfsr_raster_timing`

## Requirements
- R1: Both position registers start from 16'hFFFF. Each step shifts the state left by one, and the new bit 0 is the XOR of the old bits 15, 4, 2 and 1. A count of N means the state after N such steps, so count 1 is 16'hFFFE. A position register never holds zero.
- R2: The horizontal register steps every clock. In the clock where it equals `h_end_code`, it returns to the seed instead of stepping. If that word encodes N, a line lasts N+1 clocks.
- R3: The vertical register steps only in a clock where the horizontal register wraps, and otherwise holds its value. It returns to the seed at a line end where it equals `v_end_code`. If that word encodes M, a frame lasts (M+1) lines.
- R4: The horizontal sync flag sets on the clock edge after the horizontal count is 1. It clears on the edge after the count matches `h_sync_end_code`. If both match in the same clock, the set wins.
- R5: The vertical sync flag sets on an edge where the vertical count is 0. It clears on an edge where the vertical count matches `v_sync_end_code`.
- R6: The horizontal window flag sets on the edge after the horizontal count matches `h_act_start_code` and clears on the edge after it matches `h_act_end_code`. The vertical window flag works the same way with the vertical count. In `DISP_ON`, `de` is high only while both flags are set.
- R7: `px_x` increments on every clock edge where the horizontal window flag is set. Otherwise it loads 0 on an edge where the horizontal count matches the window start. `px_y` increments on a line wrap while the vertical window flag is set. Otherwise it loads 0 while the vertical count matches its window start. When a window flag rises, its index is 0.
- R8: `act_width` and `act_height` are plain binary. `de` is additionally held low unless `px_x < act_width` and `px_y < act_height`.
- R9: `blank_mode` is registered and takes effect one clock later. Code 0 gives normal output. Code 1 keeps both syncs running with `de` low. Codes 2 and 3 force `hsync`, `vsync` and `de` low. Sync outputs are active-high.
- R10: While `rst_n` is low, `hsync`, `vsync`, `de`, `px_x` and `px_y` are all 0, and the mode state is `DISP_OFF`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blank_mode | input | 2 | 0 normal, 1 blanked, 2/3 power-down |
| h_end_code | input | 16 | Encoded last horizontal count of a line |
| h_sync_end_code | input | 16 | Encoded horizontal count ending sync |
| h_act_start_code | input | 16 | Encoded horizontal count opening the window |
| h_act_end_code | input | 16 | Encoded horizontal count closing the window |
| v_end_code | input | 16 | Encoded last vertical count of a frame |
| v_sync_end_code | input | 16 | Encoded vertical count ending sync |
| v_act_start_code | input | 16 | Encoded vertical count opening the window |
| v_act_end_code | input | 16 | Encoded vertical count closing the window |
| act_width | input | 12 | Binary visible width |
| act_height | input | 12 | Binary visible height |
| hsync | output | 1 | Horizontal sync, active-high |
| vsync | output | 1 | Vertical sync, active-high |
| de | output | 1 | Display enable |
| px_x | output | 12 | Binary column index |
| px_y | output | 12 | Binary row index |

## Verification
Sync and window flags change one rising edge after the count that matches their boundary. Each index changes on the same edge as its flag. A change of `blank_mode` reaches the outputs one edge after it is sampled. The bench keeps its own binary-count model and advances it once per rising edge, using the inputs held at that edge. It then compares every output at the following falling edge. This keeps every comparison exactly one register stage behind the stimulus. Line and frame lengths are also measured from the spacing of sync rising edges while the mode is held at normal.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    localparam int LFSR_W = 16;
    typedef logic [LFSR_W-1:0] lfsr_t;
    localparam lfsr_t LFSR_SEED = '1;

    typedef enum logic [1:0] {
        DISP_OFF   = 2'd0,
        DISP_ON    = 2'd1,
        DISP_BLANK = 2'd2
    } disp_state_t;

    // One shift step: left shift, feedback from bits 15, 4, 2, 1
    function automatic lfsr_t lfsr_step(input lfsr_t s);
        return {s[LFSR_W-2:0], s[15] ^ s[4] ^ s[2] ^ s[1]};
    endfunction

    // State reached after n steps from the seed
    function automatic lfsr_t lfsr_encode(input int n);
        lfsr_t s;
        s = LFSR_SEED;
        for (int i = 0; i < n; i++) begin
            s = lfsr_step(s);
        end
        return s;
    endfunction

endpackage

// File: rtl/vtg_axis.sv
module vtg_axis
    import vtg_pkg::*;
#(
    parameter int IDX_W   = 12,
    parameter int SYNC_AT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  lfsr_t            end_code,
    input  lfsr_t            sync_end_code,
    input  lfsr_t            act_start_code,
    input  lfsr_t            act_end_code,
    output logic             wrap,
    output logic             sync_on,
    output logic             act_on,
    output logic [IDX_W-1:0] idx
);

    localparam lfsr_t SYNC_CODE = lfsr_encode(SYNC_AT);

    lfsr_t            pos_q;
    logic             sync_q;
    logic             act_q;
    logic [IDX_W-1:0] idx_q;

    assign wrap = adv && (pos_q == end_code);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= LFSR_SEED;
        end else if (wrap) begin
            pos_q <= LFSR_SEED;
        end else if (adv) begin
            pos_q <= lfsr_step(pos_q);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 1'b0;
            act_q  <= 1'b0;
        end else begin
            if (pos_q == SYNC_CODE) begin
                sync_q <= 1'b1;
            end else if (pos_q == sync_end_code) begin
                sync_q <= 1'b0;
            end
            if (pos_q == act_start_code) begin
                act_q <= 1'b1;
            end else if (pos_q == act_end_code) begin
                act_q <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (adv && act_q) begin
            idx_q <= idx_q + 1'b1;
        end else if (pos_q == act_start_code) begin
            idx_q <= '0;
        end
    end

    assign sync_on = sync_q;
    assign act_on  = act_q;
    assign idx     = idx_q;

    // R1
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q != '0);

    // R2
    wrap_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (pos_q == LFSR_SEED));

    // R3
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(pos_q));

    // R7
    idx_start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_q) |-> (idx_q == '0));

endmodule

// File: rtl/lfsr_raster_timing.sv
module lfsr_raster_timing
    import vtg_pkg::*;
#(
    parameter int COORD_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         blank_mode,
    input  logic [15:0]        h_end_code,
    input  logic [15:0]        h_sync_end_code,
    input  logic [15:0]        h_act_start_code,
    input  logic [15:0]        h_act_end_code,
    input  logic [15:0]        v_end_code,
    input  logic [15:0]        v_sync_end_code,
    input  logic [15:0]        v_act_start_code,
    input  logic [15:0]        v_act_end_code,
    input  logic [COORD_W-1:0] act_width,
    input  logic [COORD_W-1:0] act_height,
    output logic               hsync,
    output logic               vsync,
    output logic               de,
    output logic [COORD_W-1:0] px_x,
    output logic [COORD_W-1:0] px_y
);

    localparam int H_SYNC_AT = 1;
    localparam int V_SYNC_AT = 0;

    logic               h_wrap, v_wrap;
    logic               h_sync, v_sync, h_act, v_act;
    logic [COORD_W-1:0] h_idx, v_idx;
    logic               in_bounds;
    disp_state_t        state_q, state_d;

    vtg_axis #(.IDX_W(COORD_W), .SYNC_AT(H_SYNC_AT)) h_axis_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .adv            (1'b1),
        .end_code       (h_end_code),
        .sync_end_code  (h_sync_end_code),
        .act_start_code (h_act_start_code),
        .act_end_code   (h_act_end_code),
        .wrap           (h_wrap),
        .sync_on        (h_sync),
        .act_on         (h_act),
        .idx            (h_idx)
    );

    vtg_axis #(.IDX_W(COORD_W), .SYNC_AT(V_SYNC_AT)) v_axis_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .adv            (h_wrap),
        .end_code       (v_end_code),
        .sync_end_code  (v_sync_end_code),
        .act_start_code (v_act_start_code),
        .act_end_code   (v_act_end_code),
        .wrap           (v_wrap),
        .sync_on        (v_sync),
        .act_on         (v_act),
        .idx            (v_idx)
    );

    assign in_bounds = (h_idx < act_width) && (v_idx < act_height);

    always_comb begin
        unique case (blank_mode)
            2'b00:   state_d = DISP_ON;
            2'b01:   state_d = DISP_BLANK;
            default: state_d = DISP_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DISP_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        hsync = 1'b0;
        vsync = 1'b0;
        de    = 1'b0;
        unique case (state_q)
            DISP_ON: begin
                hsync = h_sync;
                vsync = v_sync;
                de    = h_act && v_act && in_bounds;
            end
            DISP_BLANK: begin
                hsync = h_sync;
                vsync = v_sync;
            end
            default: begin
                hsync = 1'b0;
            end
        endcase
    end

    assign px_x = h_idx;
    assign px_y = v_idx;

    // R9
    pwrdn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blank_mode[1] |=> (!hsync && !vsync && !de));

    // R3
    frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v_wrap |-> h_wrap);

endmodule

// File: tb/lfsr_raster_timing_tb.sv
module lfsr_raster_timing_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CW         = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    blank_mode = 2'd0;
    logic [15:0]   h_end_code, h_sync_end_code, h_act_start_code, h_act_end_code;
    logic [15:0]   v_end_code, v_sync_end_code, v_act_start_code, v_act_end_code;
    logic [CW-1:0] act_width, act_height;
    logic          hsync, vsync, de;
    logic [CW-1:0] px_x, px_y;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int htot, hse, has, hae, vlast, vse, vas, vae, aw, ah;
    int m_hc, m_vc, m_hs, m_vs, m_ha, m_va, m_x, m_y, m_mode;

    always #(CLK_PERIOD/2) clk = ~clk;

    lfsr_raster_timing #(.COORD_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .blank_mode(blank_mode),
        .h_end_code(h_end_code), .h_sync_end_code(h_sync_end_code),
        .h_act_start_code(h_act_start_code), .h_act_end_code(h_act_end_code),
        .v_end_code(v_end_code), .v_sync_end_code(v_sync_end_code),
        .v_act_start_code(v_act_start_code), .v_act_end_code(v_act_end_code),
        .act_width(act_width), .act_height(act_height),
        .hsync(hsync), .vsync(vsync), .de(de), .px_x(px_x), .px_y(px_y)
    );

    function automatic logic [15:0] enc(input int n);
        logic [15:0] s;
        s = 16'hFFFF;
        for (int i = 0; i < n; i++) s = {s[14:0], s[15] ^ s[4] ^ s[2] ^ s[1]};
        return s;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    task automatic apply_cfg();
        h_end_code       = enc(htot - 1);
        h_sync_end_code  = enc(hse);
        h_act_start_code = enc(has);
        h_act_end_code   = enc(hae);
        v_end_code       = enc(vlast);
        v_sync_end_code  = enc(vse);
        v_act_start_code = enc(vas);
        v_act_end_code   = enc(vae);
        act_width        = CW'(aw);
        act_height       = CW'(ah);
    endtask

    task automatic model_reset();
        m_hc = 0; m_vc = 0; m_hs = 0; m_vs = 0;
        m_ha = 0; m_va = 0; m_x = 0; m_y = 0; m_mode = 2;
    endtask

    task automatic model_step();
        int hw, vw, nhs, nvs, nha, nva, nx, ny;
        hw  = (m_hc == htot - 1);
        vw  = hw && (m_vc == vlast);
        nhs = (m_hc == 1) ? 1 : ((m_hc == hse) ? 0 : m_hs);
        nvs = (m_vc == 0) ? 1 : ((m_vc == vse) ? 0 : m_vs);
        nha = (m_hc == has) ? 1 : ((m_hc == hae) ? 0 : m_ha);
        nva = (m_vc == vas) ? 1 : ((m_vc == vae) ? 0 : m_va);
        nx  = m_ha ? ((m_x + 1) % 4096) : ((m_hc == has) ? 0 : m_x);
        ny  = (hw && m_va) ? ((m_y + 1) % 4096) : ((m_vc == vas) ? 0 : m_y);
        m_hs = nhs; m_vs = nvs; m_ha = nha; m_va = nva; m_x = nx; m_y = ny;
        m_vc = vw ? 0 : (hw ? m_vc + 1 : m_vc);
        m_hc = hw ? 0 : m_hc + 1;
        m_mode = int'(blank_mode);
    endtask

    task automatic compare_all();
        int off, ede;
        off = (m_mode >= 2);
        ede = (m_ha && m_va && m_mode == 0 && m_x < aw && m_y < ah) ? 1 : 0;
        chk("R1 R2 R4 R9", "hsync", int'(hsync), (m_hs && !off) ? 1 : 0);
        chk("R3 R5 R9", "vsync", int'(vsync), (m_vs && !off) ? 1 : 0);
        chk("R6 R8 R9", "de", int'(de), ede);
        if (ede != 0) begin
            chk("R7", "px_x", int'(px_x), m_x);
            chk("R7", "px_y", int'(px_y), m_y);
        end
    endtask

    task automatic run_cfg();
        int frame, hr0, hr1, vr0, vr1, ph, pv;
        frame = (vlast + 1) * htot;
        @(negedge clk);
        rst_n = 1'b0;
        blank_mode = 2'd0;
        apply_cfg();
        model_reset();
        @(negedge clk);
        // R10 reset state
        chk("R10", "hsync", int'(hsync), 0);
        chk("R10", "vsync", int'(vsync), 0);
        chk("R10", "de", int'(de), 0);
        chk("R10", "px_x", int'(px_x), 0);
        chk("R10", "px_y", int'(px_y), 0);
        rst_n = 1'b1;
        hr0 = -1; hr1 = -1; vr0 = -1; vr1 = -1; ph = 0; pv = 0;
        for (int c = 1; c <= 2 * frame + htot; c++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            compare_all();
            if (hsync && !ph) begin
                if (hr0 < 0) hr0 = c; else if (hr1 < 0) hr1 = c;
            end
            if (vsync && !pv) begin
                if (vr0 < 0) vr0 = c; else if (vr1 < 0) vr1 = c;
            end
            ph = int'(hsync); pv = int'(vsync);
        end
        // R2 line length, R3 frame length
        chk("R2", "line period", hr1 - hr0, htot);
        chk("R3", "frame period", vr1 - vr0, frame);
        for (int c = 0; c < frame; c++) begin
            if ($urandom % 16 == 0) blank_mode = 2'($urandom % 4);
            @(posedge clk);
            model_step();
            @(negedge clk);
            compare_all();
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        h_end_code = '0; h_sync_end_code = '0; h_act_start_code = '0; h_act_end_code = '0;
        v_end_code = '0; v_sync_end_code = '0; v_act_start_code = '0; v_act_end_code = '0;
        act_width = '0; act_height = '0;
        // R1 encoding of count 1
        chk("R1", "enc(1)", int'(enc(1)), 16'hFFFE);
        // directed: horizontal window closing on the last count of the line
        htot = 16; hse = 3; has = 4; hae = 15; vlast = 8; vse = 1; vas = 2; vae = 8;
        aw = 11; ah = 6;
        run_cfg();
        // directed: visible size smaller than windows (R8)
        htot = 30; hse = 5; has = 7; hae = 25; vlast = 12; vse = 2; vas = 4; vae = 11;
        aw = 9; ah = 3;
        run_cfg();
        for (int k = 0; k < 10; k++) begin
            htot  = 24 + int'($urandom % 25);
            hse   = 2 + int'($urandom % 5);
            has   = hse + 1 + int'($urandom % 4);
            hae   = has + 4 + int'($urandom % (htot - has - 4));
            vlast = 10 + int'($urandom % 11);
            vse   = 1 + int'($urandom % 3);
            vas   = vse + 1 + int'($urandom % 3);
            vae   = vas + 2 + int'($urandom % (vlast - vas - 1));
            aw    = (hae - has) - 2 + int'($urandom % 5);
            ah    = (vae - vas) - 1 + int'($urandom % 4);
            run_cfg();
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog run did not finish actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule